// File: doc/BRIEF.md
# FM Synthesizer Write-Recovery Guard

This block sits on the card side of an 8-bit I/O interface, in front of an FM synthesizer chip that needs a settling time after every write. It runs from the 14.318 MHz bus oscillator and keeps a busy countdown. The countdown is loaded when a write is passed to the chip. A write to the register-select port costs 12 chip cycles. A data write costs 84 chip cycles. The chip clock is the oscillator divided by four, so these are 48 and 336 oscillator ticks.

A write that arrives while the countdown is running is held: the ready line is pulled low and the write is passed on when the countdown expires. The bus forbids a single hold longer than 15.6 µs, which is 223 oscillator ticks. The data-write interval is longer than that, so the hold is capped. When the cap releases the bus early, the pending write is discarded and a sticky overrun flag is set. Reads are never held, and a status read is answered at once.

Top module: `synth_wr_guard`

## Requirements
- R1: A write whose rising strobe edge arrives while no recovery time is pending keeps `io_rdy` high. It appears on `chip_we` for exactly one cycle in the following clock cycle, with the same port bit and data.
- R2: After a forwarded write with port bit 0 (register select), the next forwarded write follows no sooner than 48 ticks later. A write held behind it is forwarded exactly 48 ticks after it.
- R3: After a forwarded write with port bit 1 (data), the next forwarded write follows no sooner than 336 ticks later. A write held behind it is forwarded exactly 336 ticks after it, provided the hold stays within the cap.
- R4: A write arriving while recovery time is pending pulls `io_rdy` low from its arrival cycle until the cycle it is forwarded in. It is not dropped.
- R5: `io_rdy` is never low for more than 223 consecutive ticks. If the pending recovery time would exceed that, `io_rdy` rises after exactly 223 low ticks and the held write never reaches `chip_we`.
- R6: `overrun` is set by a cap release and stays set through later successful writes until reset.
- R7: Reads never pull `io_rdy` low, even while recovery time is pending. `io_rdata` equals `chip_status` while `io_rd` is high with port bit 0, and is zero otherwise.
- R8: Reset clears the countdown, any hold and `overrun`. `io_rdy` is high and `chip_we` low during and after reset, and the first write after reset is forwarded without a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14.318 MHz bus oscillator, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr0 | input | 1 | Port bit: 0 register select/status, 1 data |
| io_wr | input | 1 | Write strobe, high for the whole bus cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data from the bus |
| chip_status | input | 8 | Status byte from the synthesizer |
| io_rdy | output | 1 | Bus ready, low while a write is held |
| io_rdata | output | 8 | Read data toward the bus |
| chip_we | output | 1 | One-cycle write pulse to the synthesizer |
| chip_addr0 | output | 1 | Port bit of the forwarded write |
| chip_wdata | output | 8 | Data of the forwarded write |
| overrun | output | 1 | Sticky flag: a held write was discarded at the cap |

## Verification
Writes are issued in four timing patterns: on an idle bus, directly behind a register-select write, partway through a data-write recovery, and directly behind a data write. These separate plain forwarding, the two interval lengths, a hold that ends by forwarding, and a hold that ends at the cap. Pulse spacing and the count of low-ready ticks tell an interval that is off by one from a correct one. A dropped held write shows up as a missing pulse or wrong data. Reads issued during recovery show whether reads are wrongly stalled. A reset in mid-recovery, followed by a prompt write, shows whether the countdown is really cleared.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

   typedef enum logic {
      PORT_SEL  = 1'b0,
      PORT_DATA = 1'b1
   } port_e;

   function automatic int unsigned osc_ticks(input int unsigned chip_cycles,
                                             input int unsigned div);
      return chip_cycles * div;
   endfunction

endpackage

// File: rtl/wrg_busy_timer.sv
module wrg_busy_timer
   import wrg_pkg::*;
#(
   parameter int unsigned CNT_W     = 9,
   parameter int unsigned SEL_LOAD  = 47,
   parameter int unsigned DATA_LOAD = 335
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  port_e load_port,
   output logic  busy
);

   localparam logic [CNT_W-1:0] L_SEL  = CNT_W'(SEL_LOAD);
   localparam logic [CNT_W-1:0] L_DATA = CNT_W'(DATA_LOAD);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= (load_port == PORT_DATA) ? L_DATA : L_SEL;
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R2 / R3: a load always opens a recovery window
   a_r3_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

endmodule

// File: rtl/wrg_hold_ctrl.sv
module wrg_hold_ctrl #(
   parameter int unsigned HOLD_W    = 8,
   parameter int unsigned CAP_TICKS = 223,
   parameter bit          CAP_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   output logic holding,
   output logic fire,
   output logic cap_hit
);

   assign fire = holding & ~busy;

   generate
      if (CAP_EN) begin : g_cap
         localparam logic [HOLD_W-1:0] LAST = HOLD_W'(CAP_TICKS - 1);
         logic [HOLD_W-1:0] held;

         always_ff @(posedge clk) begin
            if (!rst_n)
               held <= '0;
            else if (start)
               held <= HOLD_W'(1);
            else if (holding)
               held <= held + 1'b1;
         end

         assign cap_hit = holding & busy & (held == LAST);
      end else begin : g_nocap
         assign cap_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         holding <= 1'b0;
      else if (start)
         holding <= 1'b1;
      else if (fire | cap_hit)
         holding <= 1'b0;
   end

   // R4: a hold ends only by forwarding or by the cap
   a_r4_hold_ends_properly: assert property (@(posedge clk) disable iff (!rst_n)
      (holding && !fire && !cap_hit) |=> holding);

endmodule

// File: rtl/synth_wr_guard.sv
module synth_wr_guard
   import wrg_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned OSC_DIV     = 4,
   parameter int unsigned SEL_CYCLES  = 12,
   parameter int unsigned DATA_CYCLES = 84,
   parameter int unsigned CAP_TICKS   = 223,
   parameter bit          CAP_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_addr0,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] chip_status,
   output logic              io_rdy,
   output logic [DATA_W-1:0] io_rdata,
   output logic              chip_we,
   output logic              chip_addr0,
   output logic [DATA_W-1:0] chip_wdata,
   output logic              overrun
);

   localparam int unsigned SEL_TICKS  = osc_ticks(SEL_CYCLES, OSC_DIV);
   localparam int unsigned DATA_TICKS = osc_ticks(DATA_CYCLES, OSC_DIV);
   localparam int unsigned MAX_TICKS  = (DATA_TICKS > SEL_TICKS) ? DATA_TICKS : SEL_TICKS;
   localparam int unsigned CNT_W      = $clog2(MAX_TICKS);
   localparam int unsigned HOLD_W     = $clog2(CAP_TICKS + 1);

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (SEL_TICKS >= 2) else $error("register-select interval too short");
      assert (DATA_TICKS >= 2) else $error("data interval too short");
      assert (CAP_TICKS >= 2) else $error("CAP_TICKS must be at least 2");
   end

   logic              wr_q;
   logic              wr_rise;
   logic              busy;
   logic              holding;
   logic              fire;
   logic              cap_hit;
   logic              start_hold;
   logic              accept_now;
   logic              launch;
   port_e             pend_port;
   logic [DATA_W-1:0] pend_data;
   port_e             go_port;
   logic [DATA_W-1:0] go_data;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= io_wr;
   end

   assign wr_rise    = io_wr & ~wr_q;
   assign accept_now = wr_rise & ~busy & ~holding;
   assign start_hold = wr_rise & busy & ~holding;
   assign launch     = accept_now | fire;
   assign go_port    = fire ? pend_port : port_e'(io_addr0);
   assign go_data    = fire ? pend_data : io_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_port <= PORT_SEL;
         pend_data <= '0;
      end else if (start_hold) begin
         pend_port <= port_e'(io_addr0);
         pend_data <= io_wdata;
      end
   end

   wrg_busy_timer #(
      .CNT_W     (CNT_W),
      .SEL_LOAD  (SEL_TICKS - 1),
      .DATA_LOAD (DATA_TICKS - 1)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (launch),
      .load_port (go_port),
      .busy      (busy)
   );

   wrg_hold_ctrl #(
      .HOLD_W    (HOLD_W),
      .CAP_TICKS (CAP_TICKS),
      .CAP_EN    (CAP_EN)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_hold),
      .busy    (busy),
      .holding (holding),
      .fire    (fire),
      .cap_hit (cap_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chip_we    <= 1'b0;
         chip_addr0 <= 1'b0;
         chip_wdata <= '0;
         overrun    <= 1'b0;
      end else begin
         chip_we <= launch;
         if (launch) begin
            chip_addr0 <= go_port;
            chip_wdata <= go_data;
         end
         if (cap_hit) overrun <= 1'b1;
      end
   end

   assign io_rdy   = ~(holding | start_hold);
   assign io_rdata = (io_rd && io_addr0 == PORT_SEL) ? chip_status : '0;

   // ---------------- checks ----------------
   logic [15:0] since_we;
   logic [15:0] need_gap;
   logic        seen_we;
   logic [15:0] low_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_we <= '0;
         need_gap <= '0;
         seen_we  <= 1'b0;
         low_run  <= '0;
      end else begin
         if (chip_we) begin
            since_we <= 16'd1;
            need_gap <= chip_addr0 ? 16'(DATA_TICKS) : 16'(SEL_TICKS);
            seen_we  <= 1'b1;
         end else if (since_we != 16'hFFFF) begin
            since_we <= since_we + 1'b1;
         end
         low_run <= io_rdy ? 16'd0 : low_run + 1'b1;
      end
   end

   // R2 and R3: forwarded writes respect the interval of the one before
   a_r2_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_we && seen_we) |-> since_we >= need_gap);

   // R1: an unhindered write reaches the chip on the next cycle
   a_r1_forward_next: assert property (@(posedge clk) disable iff (!rst_n)
      accept_now |=> (chip_we && chip_wdata == $past(io_wdata)));

   generate
      if (CAP_EN) begin : g_cap_chk
         // R5: ready never held past the bus limit
         a_r5_hold_capped: assert property (@(posedge clk) disable iff (!rst_n)
            !io_rdy |-> low_run < 16'(CAP_TICKS));
      end
   endgenerate

   // R5: a capped write is discarded
   a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit |=> !chip_we);

   // R6: overrun is sticky
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   // R7: a read without a concurrent write is never stalled
   a_r7_read_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_wr) |-> io_rdy);

endmodule

// File: tb/synth_wr_guard_test.sv
module synth_wr_guard_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       io_addr0 = 1'b0;
   logic       io_wr = 1'b0;
   logic       io_rd = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] chip_status = '0;
   logic       io_rdy;
   logic [7:0] io_rdata;
   logic       chip_we;
   logic       chip_addr0;
   logic [7:0] chip_wdata;
   logic       overrun;

   always #2 clk = ~clk;   // 250 MHz

   synth_wr_guard uut (
      .clk(clk), .rst_n(rst_n), .io_addr0(io_addr0), .io_wr(io_wr),
      .io_rd(io_rd), .io_wdata(io_wdata), .chip_status(chip_status),
      .io_rdy(io_rdy), .io_rdata(io_rdata), .chip_we(chip_we),
      .chip_addr0(chip_addr0), .chip_wdata(chip_wdata), .overrun(overrun)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int n_pulse = 0;
   int last_t = 0;
   int prev_t = 0;
   int last_port = 0;
   int last_data = 0;
   bit timeout = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (chip_we) begin
         n_pulse   = n_pulse + 1;
         prev_t    = last_t;
         last_t    = cyc;
         last_port = int'(chip_addr0);
         last_data = int'(chip_wdata);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_true(input string req, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one bus write; returns the number of ticks ready was low
   task automatic do_write(input bit a0, input logic [7:0] d, output int low);
      @(negedge clk);
      io_addr0 = a0;
      io_wdata = d;
      io_wr    = 1'b1;
      low      = 0;
      for (int i = 0; i < 2000; i++) begin
         #1;
         if (io_rdy) break;
         low++;
         @(negedge clk);
      end
      @(negedge clk);
      io_wr = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      idle(3);
      #1;
      chk("R8 reset ready", int'(io_rdy), 1);
      chk("R8 reset overrun", int'(overrun), 0);
      chk("R8 reset chip_we", int'(chip_we), 0);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic t_idle_write;   // R1
      int low, n0;
      n0 = n_pulse;
      do_write(1'b0, 8'h3C, low);
      chk("R1 no hold", low, 0);
      chk("R1 one pulse", n_pulse - n0, 1);
      chk("R1 port", last_port, 0);
      chk("R1 data", last_data, 8'h3C);
      idle(400);
   endtask

   task automatic t_sel_hold;     // R2 R4
      int low, n0;
      do_write(1'b0, 8'h11, low);
      n0 = n_pulse;
      do_write(1'b1, 8'h22, low);
      chk_true("R4 held after select", low > 0, low, 1);
      chk("R4 held write kept", n_pulse - n0, 1);
      chk("R2 spacing 48", last_t - prev_t, 48);
      chk("R4 held data", last_data, 8'h22);
      chk("R4 held port", last_port, 1);
      idle(400);
   endtask

   task automatic t_data_hold;    // R3 R4
      int low;
      do_write(1'b1, 8'h33, low);
      idle(200);
      do_write(1'b0, 8'h44, low);
      chk_true("R4 held mid data", low > 0 && low < 223, low, 135);
      chk("R3 spacing 336", last_t - prev_t, 336);
      chk("R3 held data", last_data, 8'h44);
      idle(60);
   endtask

   task automatic t_data_late;    // R3 R1
      int low;
      do_write(1'b1, 8'h55, low);
      idle(340);
      do_write(1'b0, 8'h66, low);
      chk("R1 no hold after recovery", low, 0);
      chk_true("R3 spacing at least 336", last_t - prev_t >= 336, last_t - prev_t, 336);
      idle(60);
   endtask

   task automatic t_read;         // R7
      int low;
      bit rdy_ok = 1'b1;
      bit dat_ok = 1'b1;
      do_write(1'b1, 8'h77, low);
      @(negedge clk);
      io_rd = 1'b1;
      io_addr0 = 1'b0;
      chip_status = 8'hA5;
      for (int i = 0; i < 20; i++) begin
         #1;
         if (!io_rdy) rdy_ok = 1'b0;
         if (io_rdata !== 8'hA5) dat_ok = 1'b0;
         @(negedge clk);
      end
      chk("R7 read not stalled", int'(rdy_ok), 1);
      chk("R7 status returned", int'(dat_ok), 1);
      io_addr0 = 1'b1;
      #1;
      chk("R7 data port reads zero", int'(io_rdata), 0);
      chk("R7 data port read ready", int'(io_rdy), 1);
      @(negedge clk);
      io_rd = 1'b0;
      idle(400);
   endtask

   task automatic t_overrun;      // R5 R6
      int low, n0;
      chk("R6 overrun clear before", int'(overrun), 0);
      do_write(1'b1, 8'h88, low);
      n0 = n_pulse;
      do_write(1'b0, 8'h99, low);
      chk("R5 capped low ticks", low, 223);
      chk("R5 write discarded", n_pulse - n0, 0);
      chk("R6 overrun set", int'(overrun), 1);
      idle(200);
      do_write(1'b0, 8'hAA, low);
      chk("R5 next write not held", low, 0);
      chk("R5 next write data", last_data, 8'hAA);
      chk("R6 overrun sticky", int'(overrun), 1);
      idle(60);
   endtask

   task automatic t_reset_clear;  // R8
      int low, n0;
      do_write(1'b1, 8'hBB, low);
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      #1;
      chk("R8 overrun cleared", int'(overrun), 0);
      chk("R8 ready after reset", int'(io_rdy), 1);
      @(negedge clk);
      rst_n = 1'b1;
      n0 = n_pulse;
      do_write(1'b0, 8'hCC, low);
      chk("R8 busy cleared", low, 0);
      chk("R8 forwarded", n_pulse - n0, 1);
      chk("R8 data", last_data, 8'hCC);
   endtask

   initial begin
      fork
         begin
            t_reset;
            t_idle_write;
            t_sel_hold;
            t_data_hold;
            t_data_late;
            t_read;
            t_overrun;
            t_reset_clear;
         end
         begin
            repeat (200000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      if (timeout) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule